// File: doc/BRIEF.md
# Single-Core Interrupt Distributor and CPU Port

This block collects interrupt lines from private and shared sources and presents the most urgent one to a single processor core. A distributor keeps, for every supported interrupt, an enable bit, an 8-bit priority, a group bit and a trigger mode. It tracks the lifecycle of each interrupt: inactive, pending, active, and active-and-pending. A CPU port drives one of two request pins. Group 0 interrupts go to the fast request pin `fiq`, and group 1 interrupts go to the normal request pin `irq`. The core claims an interrupt through an acknowledge strobe and retires it through an end-of-interrupt strobe.

Supported interrupt IDs start at 16. IDs 16 to 31 are private to the core, and IDs 32 up to 32+NUM_SHARED-1 are shared. Line `src[k]` carries ID 16+k. A lower priority value is more urgent. The candidate for signalling must satisfy all of the following:
- It is enabled.
- It is pending.
- It is not already active.
- It is strictly more urgent than the priority mask.
- It is strictly more urgent than the running priority, which is the most urgent priority among the active interrupts.

Configuration uses a plain single-cycle write strobe with a field selector. The acknowledge and end-of-interrupt strobes are plain one-cycle pulses. They carry no back-pressure, because the block accepts one of each in every cycle.

Top module: `intc_dist_cpu`

## Requirements
- R1: After reset, every interrupt is disabled and inactive, the distributor is off, the mask is 0, and `irq` and `fiq` are both low.
- R2: Distributor enable is written with `cfg_sel`=4 and `cfg_data[0]`. While it is 0, neither request pin rises and an acknowledge returns 1023.
- R3: A per-interrupt enable is written with `cfg_sel`=0 and `cfg_data[0]`, addressed by `cfg_id`. Clearing one enable leaves the signalling of every other interrupt unchanged.
- R4: Priority is written with `cfg_sel`=1. Among eligible interrupts, the lowest priority value wins, and equal values resolve to the lower ID.
- R5: `ack_rd` high for one cycle makes `ack_vld` high in the next cycle, with `ack_id` holding the winning ID. That interrupt moves from pending to active and stops being signalled.
- R6: If an active interrupt is asserted again, it becomes active-and-pending. After its end-of-interrupt it is signalled again without any new assertion.
- R7: `eoi_wr` with `eoi_id` deactivates that interrupt in the next cycle. An end-of-interrupt naming an inactive or unsupported ID changes nothing.
- R8: The mask is written with `cfg_sel`=5. Only priorities strictly below the mask value are signalled or acknowledged.
- R9: While interrupts are active, only an interrupt strictly more urgent than the most urgent active one is signalled. This lets it preempt a less urgent active interrupt.
- R10: Trigger mode is written with `cfg_sel`=3, where `cfg_data[0]`=1 selects edge and 0 selects level.
  - Edge: a rising edge latches pending until acknowledged.
  - Level: pending follows the line, so a line dropped before acknowledge leaves nothing pending.
- R11: Group is written with `cfg_sel`=2 using `cfg_data[0]`. The winner raises `fiq` when its group is 0 and `irq` when its group is 1, and never both pins.
- R12: An acknowledge with no eligible interrupt returns ID 1023 and changes no state.
- R13: Configuration writes to IDs below 16 or above the last shared ID have no effect on any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NUM_SHARED+16 | Synchronous interrupt lines, bit k is ID 16+k |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Field selector (see R2-style encodings in requirements) |
| cfg_id | input | 10 | Target interrupt ID for per-interrupt fields |
| cfg_data | input | 8 | Write data |
| ack_rd | input | 1 | Acknowledge strobe |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being retired |
| irq | output | 1 | Normal request (group 1) |
| fiq | output | 1 | Fast request (group 0) |

## Verification
The bench aims at the following lifecycle corners. An edge pulse arriving while the same interrupt is active must not be lost; a design that drops it would stay silent after the end-of-interrupt. A level line that falls while its interrupt is active must not leave a stale pending bit; a design that keeps one would acknowledge that interrupt a second time. Priority ties and a mask equal to the priority are probed as well; an off-by-one comparison there would signal or hand out the wrong ID. Writes to unsupported IDs are also tried; a truncating ID decode would make such a write alias onto a real interrupt and raise a request pin.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ID_W        = 10;
  localparam int FIRST_ID    = 16;
  localparam int SPURIOUS_ID = 1023;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_PRIO   = 3'd1,
    SEL_GROUP  = 3'd2,
    SEL_TRIG   = 3'd3,
    SEL_DIST   = 3'd4,
    SEL_PMASK  = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/intc_line.sv
module intc_line
  import intc_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [PRIO_W-1:0] cfg_data,
  input  logic              take,
  input  logic              eoi_hit,
  output logic              pend,
  output logic              act,
  output logic              en,
  output logic [PRIO_W-1:0] prio,
  output logic              grp
);
  logic src_q;
  logic edge_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= 1'b0;
      pend      <= 1'b0;
      act       <= 1'b0;
      en        <= 1'b0;
      prio      <= '0;
      grp       <= 1'b0;
      edge_mode <= 1'b0;
    end else begin
      src_q <= src;
      if (cfg_wr) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_ENABLE: en        <= cfg_data[0];
          SEL_PRIO:   prio      <= cfg_data;
          SEL_GROUP:  grp       <= cfg_data[0];
          SEL_TRIG:   edge_mode <= cfg_data[0];
          default: ;
        endcase
      end
      if (edge_mode) pend <= (pend & ~take) | (src & ~src_q);
      else           pend <= src & ~take;
      act <= (act & ~eoi_hit) | take;
    end
  end

  AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> act);  // R5
  AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !take) |=> !act);  // R7
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend && !take && !cfg_wr) |=> pend);  // R10
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int N      = 32,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]             pend,
  input  logic [N-1:0]             act,
  input  logic [N-1:0]             en,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  input  logic [N-1:0]             grp,
  input  logic                     dist_en,
  input  logic [PRIO_W-1:0]        pmr,
  output logic                     win_vld,
  output logic [IDX_W-1:0]         win_idx,
  output logic [PRIO_W-1:0]        win_prio,
  output logic                     win_grp,
  output logic [PRIO_W:0]          run_prio
);
  logic [PRIO_W:0]   run;
  logic              found;
  logic [PRIO_W-1:0] best;
  logic [IDX_W-1:0]  bidx;

  always_comb begin
    run = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < N; i++) begin
      if (act[i] && ({1'b0, prio[i]} < run)) run = {1'b0, prio[i]};
    end
    found = 1'b0;
    best  = '0;
    bidx  = '0;
    for (int i = 0; i < N; i++) begin
      if (dist_en && en[i] && pend[i] && !act[i] && (prio[i] < pmr) &&
          ({1'b0, prio[i]} < run) && (!found || (prio[i] < best))) begin
        found = 1'b1;
        best  = prio[i];
        bidx  = IDX_W'(i);
      end
    end
    win_vld  = found;
    win_idx  = bidx;
    win_prio = best;
    win_grp  = grp[bidx];
    run_prio = run;
  end
endmodule

// File: rtl/intc_cpu_port.sv
module intc_cpu_port
  import intc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [PRIO_W-1:0] cfg_data,
  input  logic              ack_rd,
  input  logic              win_vld,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              win_grp,
  input  logic [PRIO_W:0]   run_prio,
  output logic              dist_en,
  output logic [PRIO_W-1:0] pmr,
  output logic              ack_take,
  output logic              ack_vld,
  output logic [ID_W-1:0]   ack_id,
  output logic              irq,
  output logic              fiq
);
  assign ack_take = ack_rd & win_vld;
  assign irq      = win_vld & win_grp;
  assign fiq      = win_vld & ~win_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      pmr     <= '0;
      ack_vld <= 1'b0;
      ack_id  <= ID_W'(SPURIOUS_ID);
    end else begin
      if (cfg_wr && cfg_sel_e'(cfg_sel) == SEL_DIST)  dist_en <= cfg_data[0];
      if (cfg_wr && cfg_sel_e'(cfg_sel) == SEL_PMASK) pmr     <= cfg_data;
      ack_vld <= ack_rd;
      if (ack_rd)
        ack_id <= win_vld ? (ID_W'(win_idx) + ID_W'(FIRST_ID)) : ID_W'(SPURIOUS_ID);
    end
  end

  AST_DIST_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |-> !(irq || fiq));  // R2
  AST_SINGLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && fiq));  // R11
  AST_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> (win_prio < pmr));  // R8
  AST_PREEMPT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> ({1'b0, win_prio} < run_prio));  // R9
  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !win_vld) |=> (ack_vld && ack_id == ID_W'(SPURIOUS_ID)));  // R12
endmodule

// File: rtl/intc_dist_cpu.sv
module intc_dist_cpu
  import intc_pkg::*;
#(
  parameter int NUM_SHARED = 16,
  parameter int PRIO_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SHARED+15:0] src,
  input  logic                   cfg_wr,
  input  logic [2:0]             cfg_sel,
  input  logic [ID_W-1:0]        cfg_id,
  input  logic [PRIO_W-1:0]      cfg_data,
  input  logic                   ack_rd,
  output logic                   ack_vld,
  output logic [ID_W-1:0]        ack_id,
  input  logic                   eoi_wr,
  input  logic [ID_W-1:0]        eoi_id,
  output logic                   irq,
  output logic                   fiq
);
  localparam int N     = NUM_SHARED + 16;
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]             pend_v, act_v, en_v, grp_v;
  logic [N-1:0][PRIO_W-1:0] prio_v;
  logic                     dist_en;
  logic [PRIO_W-1:0]        pmr;
  logic                     win_vld, win_grp, ack_take;
  logic [IDX_W-1:0]         win_idx;
  logic [PRIO_W-1:0]        win_prio;
  logic [PRIO_W:0]          run_prio;

  for (genvar g = 0; g < N; g++) begin : g_line
    localparam logic [ID_W-1:0] MY_ID = ID_W'(FIRST_ID + g);
    logic cfg_hit, take_g, eoi_g;
    assign cfg_hit = cfg_wr && (cfg_id == MY_ID);
    assign take_g  = ack_take && (win_idx == IDX_W'(g));
    assign eoi_g   = eoi_wr && (eoi_id == MY_ID);

    intc_line #(.PRIO_W(PRIO_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src[g]),
      .cfg_wr   (cfg_hit),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .take     (take_g),
      .eoi_hit  (eoi_g),
      .pend     (pend_v[g]),
      .act      (act_v[g]),
      .en       (en_v[g]),
      .prio     (prio_v[g]),
      .grp      (grp_v[g])
    );
  end

  intc_select #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_select (
    .pend     (pend_v),
    .act      (act_v),
    .en       (en_v),
    .prio     (prio_v),
    .grp      (grp_v),
    .dist_en  (dist_en),
    .pmr      (pmr),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_prio (win_prio),
    .win_grp  (win_grp),
    .run_prio (run_prio)
  );

  intc_cpu_port #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cpu (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .ack_rd   (ack_rd),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_prio (win_prio),
    .win_grp  (win_grp),
    .run_prio (run_prio),
    .dist_en  (dist_en),
    .pmr      (pmr),
    .ack_take (ack_take),
    .ack_vld  (ack_vld),
    .ack_id   (ack_id),
    .irq      (irq),
    .fiq      (fiq)
  );
endmodule

// File: tb/test_intc_dist_cpu.sv
module test_intc_dist_cpu;
  localparam int NSH = 16;
  localparam int NL  = NSH + 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] src = '0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [9:0]    cfg_id = '0;
  logic [7:0]    cfg_data = '0;
  logic          ack_rd = 1'b0;
  logic          ack_vld;
  logic [9:0]    ack_id;
  logic          eoi_wr = 1'b0;
  logic [9:0]    eoi_id = '0;
  logic          irq, fiq;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  intc_dist_cpu #(.NUM_SHARED(NSH)) i_intc_dist_cpu (
    .clk(clk), .rst_n(rst_n), .src(src), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_id(cfg_id), .cfg_data(cfg_data), .ack_rd(ack_rd), .ack_vld(ack_vld),
    .ack_id(ack_id), .eoi_wr(eoi_wr), .eoi_id(eoi_id), .irq(irq), .fiq(fiq)
  );

  // monitor: pops expected acknowledge results
  always @(negedge clk) begin
    if (rst_n && ack_vld) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected ack: actual %0d expected none", ack_id);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(ack_id) != e) begin
          n_bad++;
          $display("FAIL %s ack_id: actual %0d expected %0d", t, ack_id, e);
        end
      end
    end
  end

  task automatic cfg(input logic [2:0] s, input int id, input int d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_id = 10'(id); cfg_data = 8'(d);
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ack(input int exp, input string tag);
    @(negedge clk); exp_q.push_back(exp); tag_q.push_back(tag); ack_rd = 1'b1;
    @(negedge clk); ack_rd = 1'b0;
  endtask

  task automatic eoi(input int id);
    @(negedge clk); eoi_wr = 1'b1; eoi_id = 10'(id);
    @(negedge clk); eoi_wr = 1'b0;
  endtask

  task automatic set_src(input int id, input logic v);
    @(negedge clk); src[id-16] = v;
    @(negedge clk);
  endtask

  task automatic pulse_src(input int id);
    @(negedge clk); src[id-16] = 1'b1;
    @(negedge clk); src[id-16] = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_pins(input logic ei, input logic ef, input string tag);
    n_cmp++;
    if (irq !== ei || fiq !== ef) begin
      n_bad++;
      $display("FAIL %s irq/fiq: actual %b%b expected %b%b", tag, irq, fiq, ei, ef);
    end
  endtask

  task automatic summary();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d outstanding expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins(1'b0, 1'b0, "R1 reset");
    ack(1023, "R1 reset ack");

    // ID 40: level, group 1, prio 0x40
    cfg(3'd4, 0, 1);
    cfg(3'd5, 0, 8'hFF);
    cfg(3'd1, 40, 8'h40);
    cfg(3'd2, 40, 1);
    cfg(3'd0, 40, 1);
    set_src(40, 1'b1);
    chk_pins(1'b1, 1'b0, "R11 group1 to irq");

    cfg(3'd4, 0, 0);
    chk_pins(1'b0, 1'b0, "R2 dist off");
    ack(1023, "R2 dist off ack");
    cfg(3'd4, 0, 1);
    chk_pins(1'b1, 1'b0, "R2 dist on");

    // ID 20: edge, group 0, prio 0x20
    cfg(3'd1, 20, 8'h20);
    cfg(3'd3, 20, 1);
    cfg(3'd0, 20, 1);
    pulse_src(20);
    chk_pins(1'b0, 1'b1, "R10 edge latched / R11 group0");
    cfg(3'd0, 20, 0);
    chk_pins(1'b1, 1'b0, "R3 other still signalled");
    cfg(3'd0, 20, 1);
    chk_pins(1'b0, 1'b1, "R3 re-enable");

    ack(20, "R4 most urgent");
    chk_pins(1'b0, 1'b0, "R5 taken / R9 less urgent held");

    // ID 33 preempts
    cfg(3'd1, 33, 8'h10);
    cfg(3'd2, 33, 1);
    cfg(3'd0, 33, 1);
    set_src(33, 1'b1);
    chk_pins(1'b1, 1'b0, "R9 preempt");
    ack(33, "R9 preempt ack");
    set_src(33, 1'b0);
    eoi(33);
    chk_pins(1'b0, 1'b0, "R7 eoi 33 R10 level dropped");

    // active-and-pending on 20
    pulse_src(20);
    chk_pins(1'b0, 1'b0, "R6 active not re-signalled");
    eoi(20);
    chk_pins(1'b0, 1'b1, "R6 re-signalled after eoi");
    ack(20, "R6 re-ack");
    eoi(20);
    chk_pins(1'b1, 1'b0, "R7 next pending signalled");

    eoi(40);
    chk_pins(1'b1, 1'b0, "R7 eoi on inactive id");
    eoi(5);
    chk_pins(1'b1, 1'b0, "R7 eoi on unsupported id");

    cfg(3'd5, 0, 8'h40);
    chk_pins(1'b0, 1'b0, "R8 mask equal blocks");
    ack(1023, "R8 masked ack");
    cfg(3'd5, 0, 8'h41);
    chk_pins(1'b1, 1'b0, "R8 mask above passes");

    // tie 40 vs 41
    cfg(3'd1, 41, 8'h40);
    cfg(3'd2, 41, 1);
    cfg(3'd0, 41, 1);
    set_src(41, 1'b1);
    ack(40, "R4 tie lower id");
    set_src(40, 1'b0);
    eoi(40);
    ack(41, "R10 level dropped not re-pending");
    set_src(41, 1'b0);
    eoi(41);
    ack(1023, "R12 nothing eligible");
    chk_pins(1'b0, 1'b0, "R12 pins idle");

    // unsupported config ids
    src[31] = 1'b1;
    src[0]  = 1'b1;
    cfg(3'd1, 47, 8'h30);
    cfg(3'd2, 47, 1);
    cfg(3'd0, 15, 1);
    cfg(3'd0, 48, 1);
    chk_pins(1'b0, 1'b0, "R13 out of range writes ignored");
    cfg(3'd0, 47, 1);
    chk_pins(1'b1, 1'b0, "R13 last shared id");
    ack(47, "R13 last shared ack");

    cfg(3'd1, 16, 8'h30);
    cfg(3'd0, 16, 1);
    chk_pins(1'b0, 1'b0, "R9 equal priority waits");
    eoi(47);
    chk_pins(1'b0, 1'b1, "R11 tie to id16 group0");
    ack(16, "R4 tie private id");
    chk_pins(1'b0, 1'b0, "R9 after ack 16");
    eoi(16);

    summary();
    done = 1'b1;
    $finish;
  end
endmodule